// File: doc/BRIEF.md
# Paired-Lane Long Add-With-Carry Unit

This block performs one step of a multi-precision addition spread across a vector. The vector is split into pairs of lanes. In each pair, the even lane of the accumulator is added to the even lane of the first source, together with a one-bit carry. That carry is taken from bit 0 of the odd lane of a third, carry-source vector. The even lane of the result takes the sum. The odd lane of the result takes the carry-out, zero-extended to the lane width, and the accumulator's odd lane is discarded. Lanes are 32 bits or 64 bits wide, and a size bit in the instruction word selects which.

A small decoder sits in front of the datapath. It matches the 32-bit instruction word, brings out the three register indices and the size bit so that a surrounding register file can fetch the operands, and flags any word that does not match as undefined. The word is also flagged when the vector feature is configured off. The datapath reads the three operand vectors in the issue cycle and registers the result one clock later, so a destination index equal to a source index causes no hazard inside the block.

Top module: `paired_carry_add`

## Requirements
- R1: With instruction bit 22 = 0 (32-bit lanes), for every 64-bit chunk k, result bits [64k+31:64k] equal (acc + src + cin[64k+32]) mod 2^32, where acc and src are the same bits of the accumulator and first-source vectors.
- R2: With instruction bit 22 = 1 (64-bit lanes), for every 128-bit chunk j, result bits [128j+63:128j] equal (acc + src + cin[128j+64]) mod 2^64.
- R3: Only bit 0 of each odd lane of the carry-source vector affects the result. All other carry-source bits are ignored.
- R4: Each odd lane of the result holds the unsigned carry out of its pair's addition, zero-extended to the lane width. The accumulator's odd lane is never passed through.
- R5: Lane pairs are independent: no carry moves from one pair to the next.
- R6: An even lane of all ones, added to zero with a carry-in of 1, gives a sum lane of 0 and a carry lane of 1.
- R7: A word is accepted only when bits [31:23] = 010001010, bit 21 = 0, bits [15:10] = 110100 and the feature parameter is set. Any other issued word raises `resUndef` for one cycle.
- R8: `cinIdx`, `srcIdx` and `accIdx` combinationally equal instruction bits [20:16], [9:5] and [4:0], and `laneWide` equals bit 22.
- R9: An accepted issue updates `resVec` and pulses `resValid` on the next clock edge. An undefined issue, or a cycle with no issue, leaves `resVec` unchanged.
- R10: While reset is held, `resVec`, `resValid` and `resUndef` are all 0.
- R11: With 64-bit lanes, when the vector length is an odd multiple of 64 bits, the top 64 bits of the result copy the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An instruction and its operands are presented this cycle |
| instrWord | input | 32 | Instruction word |
| accVec | input | VEC_BITS | Accumulator/destination operand |
| srcVec | input | VEC_BITS | First source operand |
| cinVec | input | VEC_BITS | Carry-source operand |
| accIdx | output | 5 | Decoded accumulator/destination register index |
| srcIdx | output | 5 | Decoded first-source register index |
| cinIdx | output | 5 | Decoded carry-source register index |
| laneWide | output | 1 | Decoded size bit (1 = 64-bit lanes) |
| resVec | output | VEC_BITS | Registered result vector |
| resValid | output | 1 | One-cycle pulse: `resVec` holds a new result |
| resUndef | output | 1 | One-cycle pulse: the issued word was undefined |

## Verification
The main instance is built with a vector length of 192 bits. This gives three lane pairs at 32-bit lanes and a single 64-bit pair plus an odd leftover chunk at 64-bit lanes, so the passthrough of the leftover chunk and the pair isolation are both exercised. A second instance is built at 64 bits with the feature parameter cleared, which shows that a correctly encoded word is still rejected. Random operands at both sizes, carry-source vectors with noise in their ignored bits, and the all-ones carry case are compared each clock against a behavioural model.

// File: rtl/pca_pkg.sv
package pca_pkg;
  // Strobes passed from the decoder to the datapath
  typedef struct packed {
    logic load;       // accepted issue: capture a new result
    logic wide;       // 64-bit lanes when set
    logic flagUndef;  // issued word is not a defined encoding
  } pcaStrobes_t;

  localparam logic [8:0] OPC_HIGH = 9'b010001010;
  localparam logic [5:0] OPC_MID  = 6'b110100;
endpackage

// File: rtl/pca_decode.sv
module pca_decode
  import pca_pkg::*;
#(
  parameter bit FEATURE_ON = 1'b1
) (
  input  logic        issueValid,
  input  logic [31:0] instrWord,
  output logic [4:0]  accIdx,
  output logic [4:0]  srcIdx,
  output logic [4:0]  cinIdx,
  output logic        laneWide,
  output pcaStrobes_t strobes
);
  logic patternHit;

  always_comb begin
    patternHit = (instrWord[31:23] == OPC_HIGH) && (instrWord[21] == 1'b0) &&
                 (instrWord[15:10] == OPC_MID);
    accIdx   = instrWord[4:0];
    srcIdx   = instrWord[9:5];
    cinIdx   = instrWord[20:16];
    laneWide = instrWord[22];
    strobes.load      = issueValid && patternHit && FEATURE_ON;
    strobes.wide      = instrWord[22];
    strobes.flagUndef = issueValid && !(patternHit && FEATURE_ON);
  end
endmodule

// File: rtl/pca_pair_adder.sv
module pca_pair_adder #(
  parameter int LANE_W = 32
) (
  input  logic [LANE_W-1:0] laneA,
  input  logic [LANE_W-1:0] laneB,
  input  logic              carryIn,
  output logic [LANE_W-1:0] sum,
  output logic              carryOut
);
  logic [LANE_W:0] wideSum;

  assign wideSum  = {1'b0, laneA} + {1'b0, laneB} + {{LANE_W{1'b0}}, carryIn};
  assign sum      = wideSum[LANE_W-1:0];
  assign carryOut = wideSum[LANE_W];
endmodule

// File: rtl/pca_datapath.sv
module pca_datapath
  import pca_pkg::*;
#(
  parameter int VEC_BITS = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  pcaStrobes_t         strobes,
  input  logic [VEC_BITS-1:0] accVec,
  input  logic [VEC_BITS-1:0] srcVec,
  input  logic [VEC_BITS-1:0] cinVec,
  output logic [VEC_BITS-1:0] resVec,
  output logic                resValid,
  output logic                resUndef
);
  localparam int NCHUNK   = VEC_BITS / 64;
  localparam int NWIDE    = VEC_BITS / 128;
  localparam bit HAS_TAIL = (NCHUNK % 2) != 0;

  logic [VEC_BITS-1:0] narrowRes;
  logic [VEC_BITS-1:0] wideRes;
  logic [VEC_BITS-1:0] nextRes;

  // 32-bit lanes: one pair per 64-bit chunk
  for (genvar k = 0; k < NCHUNK; k++) begin : gNarrow
    logic [31:0] nSum;
    logic        nCo;
    pca_pair_adder #(.LANE_W(32)) uAdd (
      .laneA   (accVec[k*64 +: 32]),
      .laneB   (srcVec[k*64 +: 32]),
      .carryIn (cinVec[k*64 + 32]),
      .sum     (nSum),
      .carryOut(nCo)
    );
    assign narrowRes[k*64 +: 64] = {31'b0, nCo, nSum};
  end

  // 64-bit lanes: one pair per 128-bit chunk
  for (genvar j = 0; j < NWIDE; j++) begin : gWide
    logic [63:0] wSum;
    logic        wCo;
    pca_pair_adder #(.LANE_W(64)) uAdd (
      .laneA   (accVec[j*128 +: 64]),
      .laneB   (srcVec[j*128 +: 64]),
      .carryIn (cinVec[j*128 + 64]),
      .sum     (wSum),
      .carryOut(wCo)
    );
    assign wideRes[j*128 +: 128] = {63'b0, wCo, wSum};
  end

  // leftover chunk belongs to no pair and keeps the accumulator
  if (HAS_TAIL) begin : gTail
    assign wideRes[VEC_BITS-1 -: 64] = accVec[VEC_BITS-1 -: 64];
  end

  assign nextRes = strobes.wide ? wideRes : narrowRes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resVec   <= '0;
      resValid <= 1'b0;
      resUndef <= 1'b0;
    end else begin
      if (strobes.load) resVec <= nextRes;
      resValid <= strobes.load;
      resUndef <= strobes.flagUndef;
    end
  end

  assert_narrow_carry_lane_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !strobes.wide) |=> (resVec[63:33] == 31'b0));

  if (NWIDE > 0) begin : gWideChk
    assert_wide_carry_lane_R4: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.load && strobes.wide) |=> (resVec[127:65] == 63'b0));
  end

  assert_hold_on_reject_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(resVec));

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> resValid);

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(resValid && resUndef));
endmodule

// File: rtl/paired_carry_add.sv
module paired_carry_add
  import pca_pkg::*;
#(
  parameter int VEC_BITS   = 256,
  parameter bit FEATURE_ON = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                issueValid,
  input  logic [31:0]         instrWord,
  input  logic [VEC_BITS-1:0] accVec,
  input  logic [VEC_BITS-1:0] srcVec,
  input  logic [VEC_BITS-1:0] cinVec,
  output logic [4:0]          accIdx,
  output logic [4:0]          srcIdx,
  output logic [4:0]          cinIdx,
  output logic                laneWide,
  output logic [VEC_BITS-1:0] resVec,
  output logic                resValid,
  output logic                resUndef
);
  pcaStrobes_t strobes;

  pca_decode #(.FEATURE_ON(FEATURE_ON)) uDecode (
    .issueValid(issueValid),
    .instrWord (instrWord),
    .accIdx    (accIdx),
    .srcIdx    (srcIdx),
    .cinIdx    (cinIdx),
    .laneWide  (laneWide),
    .strobes   (strobes)
  );

  pca_datapath #(.VEC_BITS(VEC_BITS)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .accVec  (accVec),
    .srcVec  (srcVec),
    .cinVec  (cinVec),
    .resVec  (resVec),
    .resValid(resValid),
    .resUndef(resUndef)
  );
endmodule

// File: tb/paired_carry_add_tb_top.sv
module paired_carry_add_tb_top;
  localparam int VB = 192;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          issueValid = 1'b0;
  logic [31:0]   instrWord = '0;
  logic [VB-1:0] accVec = '0, srcVec = '0, cinVec = '0;
  logic [4:0]    accIdx, srcIdx, cinIdx;
  logic          laneWide;
  logic [VB-1:0] resVec;
  logic          resValid, resUndef;

  // second instance: feature configured off
  logic [63:0] offRes;
  logic [4:0]  offA, offS, offC;
  logic        offWide, offValid, offUndef;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string curTag = "R10";
  string tagPrev = "R10";

  logic [VB-1:0] expRes;
  logic          expValid, expUndef;

  always #5 clk = ~clk;

  paired_carry_add #(.VEC_BITS(VB), .FEATURE_ON(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .instrWord(instrWord),
    .accVec(accVec), .srcVec(srcVec), .cinVec(cinVec),
    .accIdx(accIdx), .srcIdx(srcIdx), .cinIdx(cinIdx), .laneWide(laneWide),
    .resVec(resVec), .resValid(resValid), .resUndef(resUndef));

  paired_carry_add #(.VEC_BITS(64), .FEATURE_ON(1'b0)) dutOff_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .instrWord(instrWord),
    .accVec(accVec[63:0]), .srcVec(srcVec[63:0]), .cinVec(cinVec[63:0]),
    .accIdx(offA), .srcIdx(offS), .cinIdx(offC), .laneWide(offWide),
    .resVec(offRes), .resValid(offValid), .resUndef(offUndef));

  function automatic logic [31:0] mkInstr(bit wide, logic [4:0] m, logic [4:0] n, logic [4:0] da);
    return {9'b010001010, wide, 1'b0, m, 6'b110100, n, da};
  endfunction

  function automatic logic [VB-1:0] rv();
    logic [VB-1:0] v;
    for (int i = 0; i < VB/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // behavioural reference
  function automatic logic [VB-1:0] refModel(logic [VB-1:0] a, logic [VB-1:0] s,
                                             logic [VB-1:0] c, bit wide);
    logic [VB-1:0] r = a;
    if (wide) begin
      for (int p = 0; p < VB/128; p++) begin
        logic [64:0] t = {1'b0, a[p*128 +: 64]} + {1'b0, s[p*128 +: 64]} + 65'(c[p*128+64]);
        r[p*128 +: 64]    = t[63:0];
        r[p*128+64 +: 64] = {63'b0, t[64]};
      end
    end else begin
      for (int p = 0; p < VB/64; p++) begin
        logic [32:0] t = {1'b0, a[p*64 +: 32]} + {1'b0, s[p*64 +: 32]} + 33'(c[p*64+32]);
        r[p*64 +: 32]    = t[31:0];
        r[p*64+32 +: 32] = {31'b0, t[32]};
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    tagPrev <= curTag;
    if (!rstN) begin
      expRes <= '0; expValid <= 1'b0; expUndef <= 1'b0;
    end else if (issueValid && instrWord[31:23] == 9'h08A && !instrWord[21] &&
                 instrWord[15:10] == 6'h34) begin
      expRes <= refModel(accVec, srcVec, cinVec, instrWord[22]);
      expValid <= 1'b1; expUndef <= 1'b0;
    end else begin
      expValid <= 1'b0; expUndef <= issueValid;
    end
  end

  task automatic chk(string tag, string what, logic [VB-1:0] act, logic [VB-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare every clock, away from the edge
  always @(posedge clk) begin
    #4;
    chk(tagPrev, "resVec", resVec, expRes);
    chk(tagPrev, "resValid", VB'(resValid), VB'(expValid));
    chk(tagPrev, "resUndef", VB'(resUndef), VB'(expUndef));
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<50000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic issue(string tag, bit wide, logic [VB-1:0] a, logic [VB-1:0] s,
                       logic [VB-1:0] c, logic [31:0] word);
    @(negedge clk);
    curTag = tag;
    accVec = a; srcVec = s; cinVec = c;
    instrWord = word; issueValid = 1'b1;
    #1;
    chk("R8", "accIdx", VB'(accIdx), VB'(word[4:0]));
    chk("R8", "srcIdx", VB'(srcIdx), VB'(word[9:5]));
    chk("R8", "cinIdx", VB'(cinIdx), VB'(word[20:16]));
    chk("R8", "laneWide", VB'(laneWide), VB'(word[22]));
    @(negedge clk);
    issueValid = 1'b0;
  endtask

  initial begin
    logic [VB-1:0] ones64, cinOne;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 / R2 random at both sizes
    for (int i = 0; i < 20; i++)
      issue("R1", 1'b0, rv(), rv(), rv(), mkInstr(1'b0, 5'($urandom), 5'($urandom), 5'($urandom)));
    for (int i = 0; i < 20; i++)
      issue("R2", 1'b1, rv(), rv(), rv(), mkInstr(1'b1, 5'($urandom), 5'($urandom), 5'($urandom)));

    // R3: noise in ignored carry-source bits
    for (int i = 0; i < 8; i++)
      issue("R3", i[0], rv(), rv(), ~'0, mkInstr(i[0], 5'd3, 5'd3, 5'd3));

    // R4: accumulator odd lanes full of ones must be replaced by carry
    issue("R4", 1'b0, ~'0 ^ {3{64'h0000_0000_FFFF_FFFF}}, '0, '0, mkInstr(1'b0, 5'd1, 5'd2, 5'd4));

    // R6 and R5: pair 0 wraps, pair 1 must stay zero
    ones64 = '0; ones64[31:0] = 32'hFFFF_FFFF;
    cinOne = '0; cinOne[32] = 1'b1;
    issue("R6", 1'b0, ones64, '0, cinOne, mkInstr(1'b0, 5'd0, 5'd0, 5'd0));
    issue("R5", 1'b0, ones64, ones64, cinOne, mkInstr(1'b0, 5'd7, 5'd8, 5'd9));
    ones64 = '0; ones64[63:0] = '1;
    cinOne = '0; cinOne[64] = 1'b1;
    issue("R6", 1'b1, ones64, '0, cinOne, mkInstr(1'b1, 5'd0, 5'd0, 5'd0));

    // R11: tail chunk passthrough at 64-bit lanes
    issue("R11", 1'b1, rv(), rv(), rv(), mkInstr(1'b1, 5'd5, 5'd6, 5'd7));

    // R7 / R9: bad encodings leave result unchanged
    issue("R7", 1'b0, rv(), rv(), rv(), mkInstr(1'b0, 5'd1, 5'd1, 5'd1) | 32'h0020_0000);
    issue("R9", 1'b0, rv(), rv(), rv(), mkInstr(1'b0, 5'd1, 5'd1, 5'd1) ^ 32'h8000_0000);
    issue("R7", 1'b0, rv(), rv(), rv(), mkInstr(1'b0, 5'd1, 5'd1, 5'd1) ^ 32'h0000_0400);

    // R7: feature off rejects a good word
    @(negedge clk);
    curTag = "R7";
    instrWord = mkInstr(1'b0, 5'd2, 5'd2, 5'd2); issueValid = 1'b1;
    @(negedge clk);
    issueValid = 1'b0;
    chk("R7", "feature-off undef", VB'(offUndef), VB'(1));
    chk("R7", "feature-off valid", VB'(offValid), VB'(0));

    // R9: idle cycles hold
    curTag = "R9";
    repeat (4) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule